// File: doc/BRIEF.md
# Processor Power-Mode Sequencer

This controller moves a processor core between full power and two low-power states. In doze the core's unit clocks stop, but snooping stays live. In nap snooping also stops and the non-essential input receivers are gated off. Software asks for a state by writing a two-bit mode request. The controller then runs the entry sequence for that state. Nap entry needs a quiesce request and acknowledge handshake with the system. While the core is in doze, a snoop hit starts a short copy-back excursion: the data cache is woken, the dirty line is flushed, and the core goes back to doze without reaching full power.

Any of five wake sources brings the core back to full power through a timed waking state. The sources are the external interrupt, the system-management interrupt, machine check, the decrementer interrupt and soft reset. A hard reset forces full power at once. The time base, caches, bus interface and clock generator are outside this block. The block sees them only as handshake signals.

States and their `state_o` codes:

| Code | State | Behaviour |
|------|-------|-----------|
| 0 | FULL | Full power |
| 1 | DOZE_ENT | Entering doze |
| 2 | DOZE | Doze |
| 3 | DOZE_SNP | Doze snoop service |
| 4 | NAP_REQ | Quiesce requested |
| 5 | NAP | Nap |
| 6 | WAKE | Waking |
| 7 | NAP_ENT | Entering nap |

Transitions:
- FULL goes to NAP_REQ when the nap bit is set. It goes to DOZE_ENT when only the doze bit is set.
- DOZE_ENT goes to DOZE after DOZE_DLY cycles.
- DOZE goes to DOZE_SNP on a snoop hit.
- DOZE_SNP goes back to DOZE when the copy-back is done.
- NAP_REQ goes to NAP_ENT on quiesce acknowledge.
- NAP_ENT goes to NAP after NAP_DLY cycles.
- Any low-power state goes to WAKE on a wake event. In DOZE_SNP this happens only once the copy-back is done.
- WAKE goes to FULL after WAKE_DLY cycles.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `hreset_n` is low, the block is in FULL and `mode_req_o` is 00, without waiting for a clock edge. The outputs are then core_clk_en=1, snoop_en=1, rx_en=1, flush_req=0 and qreq=0.
- R2: A `mode_wr` cycle loads `mode_wdata` into `mode_req_o` at the next edge. Bit 0 requests doze and bit 1 requests nap. `state_o` reports the codes 0 to 7 listed in the state table.
- R3: With only the doze bit set, FULL goes to DOZE_ENT. DOZE_ENT lasts DOZE_DLY cycles (default 4) and then becomes DOZE. In DOZE, core_clk_en=0, snoop_en=1 and rx_en=1.
- R4: A snoop hit in DOZE enters DOZE_SNP, where flush_req=1 and core_clk_en=0. The state holds until `flush_done`, then returns to DOZE.
- R5: When both mode bits are set, FULL goes to NAP_REQ. Nap takes priority over doze.
- R6: In NAP_REQ, qreq=1 until `qack` arrives. Then NAP_ENT (qreq=1, snoop_en=0) lasts NAP_DLY cycles (default 3), followed by NAP. In NAP, qreq=1 and core_clk_en, snoop_en and rx_en are all 0.
- R7: A snoop hit in NAP has no effect. The state stays NAP.
- R8: Any of ext_irq, smi_irq, mchk_irq or dec_irq, asserted in DOZE_ENT, DOZE, NAP_REQ, NAP_ENT or NAP, moves the block to WAKE at the next edge. WAKE lasts WAKE_DLY cycles (default 2) and is followed by FULL.
- R9: On entry to WAKE, the mode bit that was acted on is cleared: the nap bit from nap states and the doze bit from doze states. The other bit is kept.
- R10: A wake event in NAP_REQ drops qreq at the next edge and goes to WAKE. NAP is not entered.
- R11: `soft_rst` is a synchronous wake event. It behaves like the interrupts in R8.
- R12: In DOZE_SNP a wake event is held off until `flush_done`. `flush_done` together with a wake goes to WAKE. A wake with no `flush_done` stays in DOZE_SNP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| hreset_n | input | 1 | Hard reset, asynchronous, active low |
| mode_wr | input | 1 | Write strobe for the mode request bits |
| mode_wdata | input | 2 | Bit 0 doze, bit 1 nap |
| ext_irq | input | 1 | External interrupt |
| smi_irq | input | 1 | System-management interrupt |
| mchk_irq | input | 1 | Machine-check input |
| dec_irq | input | 1 | Decrementer interrupt |
| soft_rst | input | 1 | Soft reset, synchronous wake |
| snoop_hit | input | 1 | Snoop hit on a modified line |
| flush_done | input | 1 | Copy-back completed |
| qack | input | 1 | Quiesce acknowledge from the system |
| core_clk_en | output | 1 | Clock enable for the execution units |
| snoop_en | output | 1 | Bus snoop enable |
| rx_en | output | 1 | Enable for the non-essential input receivers |
| flush_req | output | 1 | Data-cache copy-back request |
| qreq | output | 1 | Quiesce request |
| mode_req_o | output | 2 | Current mode request bits |
| state_o | output | 3 | State code |

## Verification
Two functions can collide in the same cycle. The first is the end of a doze copy-back, and the second is a wake event. The bench raises `ext_irq` while DOZE_SNP is still waiting and checks that the service continues. It then raises `flush_done` in the same cycle as the interrupt and expects WAKE, with the doze bit cleared, at the following edge. A second collision comes from asserting both mode bits at once, where nap must win, and from raising a wake during the quiesce wait, where qreq must fall without NAP ever being reached.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [2:0] {
        PS_FULL     = 3'd0,
        PS_DOZE_ENT = 3'd1,
        PS_DOZE     = 3'd2,
        PS_DOZE_SNP = 3'd3,
        PS_NAP_REQ  = 3'd4,
        PS_NAP      = 3'd5,
        PS_WAKE     = 3'd6,
        PS_NAP_ENT  = 3'd7
    } pwr_state_e;

    localparam int MODE_DOZE = 0;
    localparam int MODE_NAP  = 1;
endpackage

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg (
    input  logic       clk,
    input  logic       hreset_n,
    input  logic       wr,
    input  logic [1:0] wdata,
    input  logic       clr_doze,
    input  logic       clr_nap,
    output logic [1:0] bits_q
);
    import pwr_seq_pkg::*;

    always_ff @(posedge clk or negedge hreset_n) begin
        if (!hreset_n) begin
            bits_q <= 2'b00;
        end else if (wr) begin
            bits_q <= wdata;
        end else begin
            if (clr_doze) bits_q[MODE_DOZE] <= 1'b0;
            if (clr_nap)  bits_q[MODE_NAP]  <= 1'b0;
        end
    end
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
    parameter int N_SRC = 5
) (
    input  logic [N_SRC-1:0] src,
    output logic             wake
);
    assign wake = |src;
endmodule

// File: rtl/pwr_delay_cnt.sv
module pwr_delay_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          hreset_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge hreset_n) begin
        if (!hreset_n)        cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
    parameter int DOZE_DLY = 4,
    parameter int NAP_DLY  = 3,
    parameter int WAKE_DLY = 2
) (
    input  logic       clk,
    input  logic       hreset_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    input  logic       ext_irq,
    input  logic       smi_irq,
    input  logic       mchk_irq,
    input  logic       dec_irq,
    input  logic       soft_rst,
    input  logic       snoop_hit,
    input  logic       flush_done,
    input  logic       qack,
    output logic       core_clk_en,
    output logic       snoop_en,
    output logic       rx_en,
    output logic       flush_req,
    output logic       qreq,
    output logic [1:0] mode_req_o,
    output logic [2:0] state_o
);
    import pwr_seq_pkg::*;

    localparam int MAX_DLY = (DOZE_DLY > NAP_DLY)
                           ? ((DOZE_DLY > WAKE_DLY) ? DOZE_DLY : WAKE_DLY)
                           : ((NAP_DLY > WAKE_DLY) ? NAP_DLY : WAKE_DLY);
    localparam int CW      = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY);
    localparam int N_WAKE  = 5;

    pwr_state_e    state_q, state_d;
    logic          wake, cnt_zero, cnt_load;
    logic [CW-1:0] cnt_val;
    logic          clr_doze, clr_nap;
    logic [1:0]    mode_q;

    pwr_mode_reg u_mode (
        .clk      (clk),
        .hreset_n (hreset_n),
        .wr       (mode_wr),
        .wdata    (mode_wdata),
        .clr_doze (clr_doze),
        .clr_nap  (clr_nap),
        .bits_q   (mode_q)
    );

    pwr_wake_detect #(.N_SRC(N_WAKE)) u_wake (
        .src  ({ext_irq, smi_irq, mchk_irq, dec_irq, soft_rst}),
        .wake (wake)
    );

    pwr_delay_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .hreset_n (hreset_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    // State register
    always_ff @(posedge clk or negedge hreset_n) begin
        if (!hreset_n) state_q <= PS_FULL;
        else           state_q <= state_d;
    end

    // Next-state, delay loading and mode-bit clearing
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        clr_doze = 1'b0;
        clr_nap  = 1'b0;
        unique case (state_q)
            PS_FULL: begin
                if (mode_q[MODE_NAP]) begin
                    state_d = PS_NAP_REQ;
                end else if (mode_q[MODE_DOZE]) begin
                    state_d  = PS_DOZE_ENT;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(DOZE_DLY - 1);
                end
            end
            PS_DOZE_ENT, PS_DOZE: begin
                if (wake) begin
                    state_d  = PS_WAKE;
                    clr_doze = 1'b1;
                end else if (state_q == PS_DOZE_ENT && cnt_zero) begin
                    state_d = PS_DOZE;
                end else if (state_q == PS_DOZE && snoop_hit) begin
                    state_d = PS_DOZE_SNP;
                end
            end
            PS_DOZE_SNP: begin
                if (flush_done) begin
                    if (wake) begin
                        state_d  = PS_WAKE;
                        clr_doze = 1'b1;
                    end else begin
                        state_d = PS_DOZE;
                    end
                end
            end
            PS_NAP_REQ: begin
                if (wake) begin
                    state_d = PS_WAKE;
                    clr_nap = 1'b1;
                end else if (qack) begin
                    state_d  = PS_NAP_ENT;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(NAP_DLY - 1);
                end
            end
            PS_NAP_ENT, PS_NAP: begin
                if (wake) begin
                    state_d = PS_WAKE;
                    clr_nap = 1'b1;
                end else if (state_q == PS_NAP_ENT && cnt_zero) begin
                    state_d = PS_NAP;
                end
            end
            PS_WAKE: begin
                if (cnt_zero) state_d = PS_FULL;
            end
        endcase
        if (state_d == PS_WAKE && state_q != PS_WAKE) begin
            cnt_load = 1'b1;
            cnt_val  = CW'(WAKE_DLY - 1);
        end
    end

    // Outputs per state
    always_comb begin
        core_clk_en = 1'b1;
        snoop_en    = 1'b1;
        rx_en       = 1'b1;
        flush_req   = 1'b0;
        qreq        = 1'b0;
        unique case (state_q)
            PS_FULL, PS_DOZE_ENT, PS_WAKE: ;
            PS_DOZE:     core_clk_en = 1'b0;
            PS_DOZE_SNP: begin
                core_clk_en = 1'b0;
                flush_req   = 1'b1;
            end
            PS_NAP_REQ:  qreq = 1'b1;
            PS_NAP_ENT: begin
                qreq     = 1'b1;
                snoop_en = 1'b0;
            end
            PS_NAP: begin
                qreq        = 1'b1;
                core_clk_en = 1'b0;
                snoop_en    = 1'b0;
                rx_en       = 1'b0;
            end
        endcase
    end

    assign mode_req_o = mode_q;
    assign state_o    = state_q;

    // NAP_ENT is reached only from NAP_REQ after an acknowledge
    assert_nap_needs_qack_R6: assert property (@(posedge clk) disable iff (!hreset_n)
        (state_q == PS_NAP_ENT && $past(state_q) == PS_NAP_REQ) |-> $past(qack));

    // A wake in NAP leads to WAKE at the next edge
    assert_wake_from_nap_R8: assert property (@(posedge clk) disable iff (!hreset_n)
        (state_q == PS_NAP && wake) |=> (state_q == PS_WAKE));

    // The copy-back request starts only from a snoop hit in DOZE
    assert_svc_from_snoop_R4: assert property (@(posedge clk) disable iff (!hreset_n)
        $rose(flush_req) |-> ($past(snoop_hit) && $past(state_q) == PS_DOZE));

    // Leaving a nap state for WAKE clears the nap request
    assert_nap_clear_R9: assert property (@(posedge clk) disable iff (!hreset_n)
        (state_q == PS_WAKE && $past(state_q) == PS_NAP && !$past(mode_wr)) |-> !mode_q[MODE_NAP]);

    // A wake in NAP_REQ must withdraw qreq at once
    assert_qreq_withdraw_R10: assert property (@(posedge clk) disable iff (!hreset_n)
        (state_q == PS_NAP_REQ && wake) |=> !qreq);
endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
    logic       clk = 1'b0;
    logic       hreset_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic       ext_irq = 1'b0, smi_irq = 1'b0, mchk_irq = 1'b0, dec_irq = 1'b0, soft_rst = 1'b0;
    logic       snoop_hit = 1'b0, flush_done = 1'b0, qack = 1'b0;
    logic       core_clk_en, snoop_en, rx_en, flush_req, qreq;
    logic [1:0] mode_req_o;
    logic [2:0] state_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_seq_ctrl u0 (
        .clk(clk), .hreset_n(hreset_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .ext_irq(ext_irq), .smi_irq(smi_irq), .mchk_irq(mchk_irq), .dec_irq(dec_irq),
        .soft_rst(soft_rst), .snoop_hit(snoop_hit), .flush_done(flush_done), .qack(qack),
        .core_clk_en(core_clk_en), .snoop_en(snoop_en), .rx_en(rx_en),
        .flush_req(flush_req), .qreq(qreq), .mode_req_o(mode_req_o), .state_o(state_o)
    );

    // Vector: req, wr, wdata, {ext,smi,mchk,dec,srst}, {snoop,done,qack},
    //         expected state, {qreq,core,snoop_en,rx,flush}, expected mode bits
    localparam int NV = 41;
    localparam logic [24:0] VEC [NV] = '{
        // doze entry, snoop service, external wake (R2 R3 R4 R8 R9)
        {4'd2, 1'b1, 2'b01, 5'b00000, 3'b000, 3'd0, 5'b01110, 2'b01},
        {4'd3, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd1, 5'b01110, 2'b01},
        {4'd3, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd1, 5'b01110, 2'b01},
        {4'd3, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd1, 5'b01110, 2'b01},
        {4'd3, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd1, 5'b01110, 2'b01},
        {4'd3, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd2, 5'b00110, 2'b01},
        {4'd4, 1'b0, 2'b00, 5'b00000, 3'b100, 3'd3, 5'b00111, 2'b01},
        {4'd4, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd3, 5'b00111, 2'b01},
        {4'd4, 1'b0, 2'b00, 5'b00000, 3'b010, 3'd2, 5'b00110, 2'b01},
        {4'd9, 1'b0, 2'b00, 5'b10000, 3'b000, 3'd6, 5'b01110, 2'b00},
        {4'd8, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd6, 5'b01110, 2'b00},
        {4'd8, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd0, 5'b01110, 2'b00},
        // nap handshake, snoop ignored, decrementer wake (R6 R7 R8)
        {4'd2, 1'b1, 2'b10, 5'b00000, 3'b000, 3'd0, 5'b01110, 2'b10},
        {4'd6, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd4, 5'b11110, 2'b10},
        {4'd6, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd4, 5'b11110, 2'b10},
        {4'd6, 1'b0, 2'b00, 5'b00000, 3'b001, 3'd7, 5'b11010, 2'b10},
        {4'd6, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd7, 5'b11010, 2'b10},
        {4'd6, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd7, 5'b11010, 2'b10},
        {4'd6, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd5, 5'b10000, 2'b10},
        {4'd7, 1'b0, 2'b00, 5'b00000, 3'b100, 3'd5, 5'b10000, 2'b10},
        {4'd8, 1'b0, 2'b00, 5'b00010, 3'b000, 3'd6, 5'b01110, 2'b00},
        {4'd8, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd6, 5'b01110, 2'b00},
        {4'd8, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd0, 5'b01110, 2'b00},
        // both bits: nap priority, abort in quiesce wait, soft reset (R5 R10 R11)
        {4'd5, 1'b1, 2'b11, 5'b00000, 3'b000, 3'd0, 5'b01110, 2'b11},
        {4'd5, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd4, 5'b11110, 2'b11},
        {4'd10,1'b0, 2'b00, 5'b01000, 3'b000, 3'd6, 5'b01110, 2'b01},
        {4'd10,1'b0, 2'b00, 5'b00000, 3'b000, 3'd6, 5'b01110, 2'b01},
        {4'd9, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd0, 5'b01110, 2'b01},
        {4'd9, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd1, 5'b01110, 2'b01},
        {4'd11,1'b0, 2'b00, 5'b00001, 3'b000, 3'd6, 5'b01110, 2'b00},
        {4'd11,1'b0, 2'b00, 5'b00000, 3'b000, 3'd6, 5'b01110, 2'b00},
        {4'd11,1'b0, 2'b00, 5'b00000, 3'b000, 3'd0, 5'b01110, 2'b00},
        // doze then machine check
        {4'd2, 1'b1, 2'b01, 5'b00000, 3'b000, 3'd0, 5'b01110, 2'b01},
        {4'd3, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd1, 5'b01110, 2'b01},
        {4'd3, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd1, 5'b01110, 2'b01},
        {4'd3, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd1, 5'b01110, 2'b01},
        {4'd3, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd1, 5'b01110, 2'b01},
        {4'd3, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd2, 5'b00110, 2'b01},
        {4'd8, 1'b0, 2'b00, 5'b00100, 3'b000, 3'd6, 5'b01110, 2'b00},
        {4'd8, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd6, 5'b01110, 2'b00},
        {4'd8, 1'b0, 2'b00, 5'b00000, 3'b000, 3'd0, 5'b01110, 2'b00}
    };

    task automatic check(input int req, input logic [9:0] got, input logic [9:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got state/out/mode %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [1:0] wd, input logic [4:0] ev,
                         input logic [2:0] sdq);
        mode_wr = wr; mode_wdata = wd;
        {ext_irq, smi_irq, mchk_irq, dec_irq, soft_rst} = ev;
        {snoop_hit, flush_done, qack} = sdq;
    endtask

    function automatic logic [9:0] observed();
        return {state_o, qreq, core_clk_en, snoop_en, rx_en, flush_req, mode_req_o};
    endfunction

    task automatic step(input logic wr, input logic [1:0] wd, input logic [4:0] ev,
                        input logic [2:0] sdq);
        @(negedge clk);
        drive(wr, wd, ev, sdq);
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state, checked while reset is held
        #12;
        check(1, observed(), {3'd0, 5'b01110, 2'b00});
        @(negedge clk);
        hreset_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][20], VEC[i][19:18], VEC[i][17:13], VEC[i][12:10]);
            check(int'(VEC[i][24:21]), observed(), VEC[i][9:0]);
        end

        // R12: a wake during copy-back waits for flush_done
        step(1'b1, 2'b01, 5'b0, 3'b000);
        for (int k = 0; k < 5; k++) step(1'b0, 2'b00, 5'b0, 3'b000);
        check(3, observed(), {3'd2, 5'b00110, 2'b01});
        step(1'b0, 2'b00, 5'b10000, 3'b100);   // wake and snoop together: wake wins
        check(8, observed(), {3'd6, 5'b01110, 2'b00});
        step(1'b0, 2'b00, 5'b0, 3'b000);
        step(1'b0, 2'b00, 5'b0, 3'b000);
        step(1'b1, 2'b01, 5'b0, 3'b000);
        for (int k = 0; k < 5; k++) step(1'b0, 2'b00, 5'b0, 3'b000);
        step(1'b0, 2'b00, 5'b0, 3'b100);
        check(4, observed(), {3'd3, 5'b00111, 2'b01});
        step(1'b0, 2'b00, 5'b10000, 3'b000);    // R12 wake held off
        check(12, observed(), {3'd3, 5'b00111, 2'b01});
        step(1'b0, 2'b00, 5'b10000, 3'b010);    // R12 done and wake together
        check(12, observed(), {3'd6, 5'b01110, 2'b00});
        step(1'b0, 2'b00, 5'b0, 3'b000);
        step(1'b0, 2'b00, 5'b0, 3'b000);
        check(8, observed(), {3'd0, 5'b01110, 2'b00});

        // R1: asynchronous hard reset during the quiesce wait
        step(1'b1, 2'b10, 5'b0, 3'b000);
        step(1'b0, 2'b00, 5'b0, 3'b000);
        check(6, observed(), {3'd4, 5'b11110, 2'b10});
        @(negedge clk);
        drive(1'b0, 2'b00, 5'b0, 3'b000);
        #2 hreset_n = 1'b0;
        #1;
        check(1, observed(), {3'd0, 5'b01110, 2'b00});
        @(negedge clk);
        hreset_n = 1'b1;
        step(1'b0, 2'b00, 5'b0, 3'b000);
        check(1, observed(), {3'd0, 5'b01110, 2'b00});

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule